// File: doc/BRIEF.md
# Fixed-Head Storage Status Word and Track Write Guard

This block builds the 16-bit status word that a host reads back from the command side of a fixed-head disk or drum controller. It also enforces a write guard over a run of low-numbered tracks. The guard is set by a protect switch together with a protected-track count. The block takes live inputs from the timing logic and the data path: whether a medium is attached, busy, the sector-clock phase flag, the next-sector number, the current track and the transfer direction. It also takes single-cycle events that set or clear the three static status bits.

A write aimed at a guarded track is never refused and never flagged. The write sequence runs to completion while the storage write-enable output stays low, so the data is simply lost. Software learns about the guard only by testing the writing-enabled bit before it starts a write. In disk mode, each load of the command word starts a read-inhibit window that lasts a fixed number of word times. This block only counts the word-time strobes; generating them is out of scope.

Top module: `fhd_status_guard`

## Requirements
- R1: The status word carries the sector-clock phase flag in bit 15, the next-sector number in bits 14:8, ready (equal to `attached`) in bit 7 and busy in bit 0. Bit 4 always reads 0.
- R2: While `attached` is low, bits 15:6 and bit 0 read 0.
- R3: Bit 2 (writing enabled) is 1 when `prot_sw` is low, or when `cur_trk` is greater than or equal to the effective protected-track count. Otherwise it is 0.
- R4: In disk mode (`drum_mode`=0) a `prot_count` above 128 acts as 128. In drum mode the given count, up to 768, is used as is.
- R5: `mem_we` follows `wr_req` only while writing is enabled. A suppressed write sets neither the abort bit nor any other error bit.
- R6: In disk mode, a `cw_load` pulse starts a window of 64 `word_tick` strobes. Bit 6 (read inhibit) is 1 while that window runs, `wr_dir` is 0 and `attached` is 1. After the 64th strobe, bit 6 returns to 0.
- R7: In drum mode, `cw_load` does not start the read-inhibit window.
- R8: A `sec_match` pulse sets bit 5 (sector coincidence). A `ctl_clear` pulse clears it, and `ctl_clear` wins if both arrive in the same cycle.
- R9: A `start` pulse while `attached` is 0 sets bit 3 (abort).
- R10: In disk mode, a `write_done` pulse sets bit 1 (parity). In drum mode it has no effect.
- R11: A `start` pulse clears bits 5, 3 and 1 before any abort is recorded.
- R12: While `rst` is high, `status_word` and `mem_we` read 0. Reset also clears the static bits and stops the inhibit window.
- R13: `status_word` and `mem_we` are registered. Each reflects the inputs and state present at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drum_mode | input | 1 | 1 selects drum behaviour, 0 selects disk behaviour |
| prot_sw | input | 1 | Protect switch; 1 guards low tracks |
| prot_count | input | 10 | Protected-track count (1..128 disk, 1..768 drum) |
| cur_trk | input | 10 | Track number from the command word |
| wr_dir | input | 1 | Command direction; 1 means write |
| attached | input | 1 | Medium present and ready |
| busy | input | 1 | Transfer in progress |
| scp_flag | input | 1 | Sector-clock phase flag |
| next_sec | input | 7 | Next-sector number |
| cw_load | input | 1 | Pulse: command word written |
| word_tick | input | 1 | Pulse: one word time elapsed |
| sec_match | input | 1 | Pulse: transfer reached target sector |
| ctl_clear | input | 1 | Pulse: data-channel control cleared |
| start | input | 1 | Pulse: new transfer started |
| write_done | input | 1 | Pulse: write sequence completed |
| wr_req | input | 1 | Storage write request from the data path |
| status_word | output | 16 | Registered status word |
| mem_we | output | 1 | Registered storage write enable (write current) |

## Verification
A vector table sweeps the guard comparison across switch off, tracks just below and at the count, the disk clamp on a count of 512 against the same count in drum mode, and the largest drum count at tracks 767 and 768. These cases separate an off-by-one in the comparison from a missing clamp or a clamp applied in the wrong mode. The same vectors toggle `attached`, `scp_flag`, `busy` and `next_sec`, so a wrong bit position or a missing gate on the live fields shows up. Directed sequences then drive the static-bit events singly and together, which tells apart set and clear priority and mode dependence. The read-inhibit window is probed at its 63rd and 64th strobe, so a window that is one strobe too long or too short is caught.

// File: rtl/fhd_status_pkg.sv
package fhd_status_pkg;
  localparam int STATUS_W = 16;
  localparam int NSEC_W   = 7;
  // status bit positions (decoded by host software)
  localparam int B_SCP  = 15;
  localparam int B_NSLO = 8;
  localparam int B_RDY  = 7;
  localparam int B_RIF  = 6;
  localparam int B_SAC  = 5;
  localparam int B_ABO  = 3;
  localparam int B_WEN  = 2;
  localparam int B_PER  = 1;
  localparam int B_BSY  = 0;

  typedef struct packed {
    logic sac;
    logic abo;
    logic per;
  } sticky_t;
endpackage

// File: rtl/fhd_trk_guard.sv
module fhd_trk_guard #(
  parameter int TRK_W        = 10,
  parameter int DISK_MAX_CNT = 128
) (
  input  logic             drum_mode,
  input  logic             prot_sw,
  input  logic [TRK_W-1:0] prot_count,
  input  logic [TRK_W-1:0] cur_trk,
  output logic             wen
);
  logic [TRK_W-1:0] limit;

  generate
    if (DISK_MAX_CNT < (1 << TRK_W)) begin : g_clamp
      localparam logic [TRK_W-1:0] DISK_CAP = TRK_W'(DISK_MAX_CNT);
      always_comb begin
        if (!drum_mode && (prot_count > DISK_CAP)) limit = DISK_CAP;
        else                                       limit = prot_count;
      end
    end else begin : g_noclamp
      always_comb limit = prot_count;
    end
  endgenerate

  always_comb wen = !prot_sw || (cur_trk >= limit);
endmodule

// File: rtl/fhd_inhibit_timer.sv
module fhd_inhibit_timer #(
  parameter int INH_WORDS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic active
);
  localparam int TW = $clog2(INH_WORDS + 1);
  localparam logic [TW-1:0] RELOAD = TW'(INH_WORDS);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= RELOAD;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  always_comb active = (cnt != '0);

  p_tmr_load_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && load) |-> cnt == RELOAD);
  p_tmr_step_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && tick && !load && cnt != '0) |-> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/fhd_sticky_bits.sv
module fhd_sticky_bits
  import fhd_status_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    drum_mode,
  input  logic    attached,
  input  logic    start,
  input  logic    sec_match,
  input  logic    ctl_clear,
  input  logic    write_done,
  output sticky_t bits
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
    end else if (start) begin
      bits.sac <= 1'b0;
      bits.per <= 1'b0;
      bits.abo <= !attached;
    end else begin
      if (ctl_clear)      bits.sac <= 1'b0;
      else if (sec_match) bits.sac <= 1'b1;
      if (write_done && !drum_mode) bits.per <= 1'b1;
    end
  end

  p_start_clears_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && start) |-> (!bits.sac && !bits.per && bits.abo == !$past(attached)));
  p_sac_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ctl_clear && !start) |-> !bits.sac);
  p_drum_no_par_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && drum_mode && !start) && !$past(bits.per) |-> !bits.per);
endmodule

// File: rtl/fhd_status_guard.sv
module fhd_status_guard
  import fhd_status_pkg::*;
#(
  parameter int TRK_W        = 10,
  parameter int DISK_MAX_CNT = 128,
  parameter int INH_WORDS    = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                drum_mode,
  input  logic                prot_sw,
  input  logic [TRK_W-1:0]    prot_count,
  input  logic [TRK_W-1:0]    cur_trk,
  input  logic                wr_dir,
  input  logic                attached,
  input  logic                busy,
  input  logic                scp_flag,
  input  logic [NSEC_W-1:0]   next_sec,
  input  logic                cw_load,
  input  logic                word_tick,
  input  logic                sec_match,
  input  logic                ctl_clear,
  input  logic                start,
  input  logic                write_done,
  input  logic                wr_req,
  output logic [STATUS_W-1:0] status_word,
  output logic                mem_we
);
  logic    wen;
  logic    inh_active;
  sticky_t sticky;
  logic [STATUS_W-1:0] nxt;

  fhd_trk_guard #(.TRK_W(TRK_W), .DISK_MAX_CNT(DISK_MAX_CNT)) u_guard (
    .drum_mode (drum_mode),
    .prot_sw   (prot_sw),
    .prot_count(prot_count),
    .cur_trk   (cur_trk),
    .wen       (wen)
  );

  fhd_inhibit_timer #(.INH_WORDS(INH_WORDS)) u_inh (
    .clk   (clk),
    .rst   (rst),
    .load  (cw_load && !drum_mode),
    .tick  (word_tick),
    .active(inh_active)
  );

  fhd_sticky_bits u_sticky (
    .clk       (clk),
    .rst       (rst),
    .drum_mode (drum_mode),
    .attached  (attached),
    .start     (start),
    .sec_match (sec_match),
    .ctl_clear (ctl_clear),
    .write_done(write_done),
    .bits      (sticky)
  );

  always_comb begin
    nxt = '0;
    nxt[B_SCP]                   = scp_flag && attached;
    nxt[B_NSLO +: NSEC_W]        = attached ? next_sec : '0;
    nxt[B_RDY]                   = attached;
    nxt[B_RIF]                   = inh_active && !wr_dir && attached;
    nxt[B_SAC]                   = sticky.sac;
    nxt[B_ABO]                   = sticky.abo;
    nxt[B_WEN]                   = wen;
    nxt[B_PER]                   = sticky.per;
    nxt[B_BSY]                   = busy && attached;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_word <= '0;
      mem_we      <= 1'b0;
    end else begin
      status_word <= nxt;
      mem_we      <= wr_req && wen;
    end
  end

  p_we_needs_wen_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> status_word[B_WEN]);
  p_we_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(wr_req));
  p_unattached_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !attached) |-> (status_word[15:6] == '0 && !status_word[B_BSY]));
  p_switch_off_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !prot_sw) |-> status_word[B_WEN]);
  p_bit4_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !status_word[4]);
endmodule

// File: tb/sim_fhd_status_guard.sv
module sim_fhd_status_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drum_mode = 0, prot_sw = 0, wr_dir = 0, attached = 0, busy = 0, scp_flag = 0;
  logic [9:0] prot_count = 10'd1, cur_trk = '0;
  logic [6:0] next_sec = '0;
  logic cw_load = 0, word_tick = 0, sec_match = 0, ctl_clear = 0, start = 0;
  logic write_done = 0, wr_req = 0;
  logic [15:0] status_word;
  logic mem_we;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  fhd_status_guard u0 (
    .clk(clk), .rst(rst), .drum_mode(drum_mode), .prot_sw(prot_sw),
    .prot_count(prot_count), .cur_trk(cur_trk), .wr_dir(wr_dir),
    .attached(attached), .busy(busy), .scp_flag(scp_flag), .next_sec(next_sec),
    .cw_load(cw_load), .word_tick(word_tick), .sec_match(sec_match),
    .ctl_clear(ctl_clear), .start(start), .write_done(write_done),
    .wr_req(wr_req), .status_word(status_word), .mem_we(mem_we)
  );

  typedef struct packed {
    logic       drum;
    logic       psw;
    logic [9:0] cnt;
    logic [9:0] trk;
    logic       att;
    logic       scp;
    logic       bsy;
    logic [6:0] nsec;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 10'd1,   10'd0,   1'b1, 1'b0, 1'b0, 7'h05, 16'h0584},
    '{1'b0, 1'b1, 10'd4,   10'd3,   1'b1, 1'b1, 1'b1, 7'h10, 16'h9081},
    '{1'b0, 1'b1, 10'd4,   10'd4,   1'b1, 1'b0, 1'b0, 7'h00, 16'h0084},
    '{1'b0, 1'b1, 10'd128, 10'd200, 1'b0, 1'b1, 1'b1, 7'h7F, 16'h0004},
    '{1'b0, 1'b1, 10'd512, 10'd200, 1'b1, 1'b0, 1'b0, 7'h00, 16'h0084},
    '{1'b1, 1'b1, 10'd512, 10'd200, 1'b1, 1'b0, 1'b0, 7'h00, 16'h0080},
    '{1'b1, 1'b1, 10'd768, 10'd767, 1'b1, 1'b0, 1'b1, 7'h1F, 16'h1F81},
    '{1'b1, 1'b1, 10'd768, 10'd768, 1'b1, 1'b0, 1'b0, 7'h00, 16'h0084},
    '{1'b1, 1'b0, 10'd768, 10'd0,   1'b1, 1'b0, 1'b0, 7'h00, 16'h0084},
    '{1'b0, 1'b1, 10'd1,   10'd0,   1'b1, 1'b0, 1'b0, 7'h00, 16'h0080}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R12: reset holds outputs at zero
    wr_req = 1'b1;
    step(); step();
    chk("R12 status in reset", status_word, 16'h0000);
    chk("R12 mem_we in reset", {15'd0, mem_we}, 16'h0000);
    rst = 1'b0;
    wr_req = 1'b0;
    step();
    chk("R2 unattached after reset", status_word, 16'h0004);

    // R1 R2 R3 R4 R5 vector sweep
    for (int i = 0; i < NV; i++) begin
      drum_mode = VECS[i].drum; prot_sw = VECS[i].psw; prot_count = VECS[i].cnt;
      cur_trk = VECS[i].trk; attached = VECS[i].att; scp_flag = VECS[i].scp;
      busy = VECS[i].bsy; next_sec = VECS[i].nsec; wr_req = 1'b1;
      step();
      chk($sformatf("R1/R2/R3/R4 vector %0d", i), status_word, VECS[i].exp);
      chk($sformatf("R5 write gate vector %0d", i), {15'd0, mem_we}, {15'd0, VECS[i].exp[2]});
    end

    // R5: suppressed write raises no error bit
    drum_mode = 0; prot_sw = 1; prot_count = 10'd8; cur_trk = 10'd2;
    attached = 1; scp_flag = 0; busy = 0; next_sec = 0; wr_req = 1;
    step(); step();
    chk("R5 suppressed write status", status_word, 16'h0080);
    chk("R5 suppressed write enable", {15'd0, mem_we}, 16'h0000);
    wr_req = 0; prot_sw = 0;

    // R9: start without medium
    attached = 0;
    start = 1; step(); start = 0; step();
    chk("R9 abort on unattached start", status_word, 16'h000C);
    attached = 1;
    start = 1; step(); start = 0; step();
    chk("R11 start clears abort", status_word, 16'h0084);

    // R8: coincidence set / clear / priority
    sec_match = 1; step(); sec_match = 0; step();
    chk("R8 coincidence set", status_word, 16'h00A4);
    ctl_clear = 1; step(); ctl_clear = 0; step();
    chk("R8 coincidence cleared", status_word, 16'h0084);
    sec_match = 1; step(); sec_match = 0; step();
    sec_match = 1; ctl_clear = 1; step(); sec_match = 0; ctl_clear = 0; step();
    chk("R8 clear wins over set", status_word, 16'h0084);

    // R10 / R11: parity in disk mode, cleared by start
    write_done = 1; step(); write_done = 0; step();
    chk("R10 disk parity set", status_word, 16'h0086);
    sec_match = 1; step(); sec_match = 0; step();
    chk("R8 coincidence with parity", status_word, 16'h00A6);
    start = 1; step(); start = 0; step();
    chk("R11 start clears static bits", status_word, 16'h0084);
    drum_mode = 1;
    write_done = 1; step(); write_done = 0; step();
    chk("R10 drum ignores write_done", status_word, 16'h0084);

    // R7: drum mode ignores cw_load
    cw_load = 1; step(); cw_load = 0; step();
    chk("R7 drum no read inhibit", status_word, 16'h0084);

    // R6: disk read inhibit window
    drum_mode = 0; wr_dir = 0;
    cw_load = 1; step(); cw_load = 0; step();
    chk("R6 inhibit starts", status_word, 16'h00C4);
    wr_dir = 1; step();
    chk("R6 inhibit hidden for write", status_word, 16'h0084);
    wr_dir = 0; step();
    chk("R6 inhibit visible again", status_word, 16'h00C4);
    word_tick = 1;
    repeat (63) step();
    word_tick = 0; step();
    chk("R6 inhibit after 63 ticks", status_word, 16'h00C4);
    word_tick = 1; step(); word_tick = 0; step();
    chk("R6 inhibit ends after 64 ticks", status_word, 16'h0084);

    // R13: registered latency of one edge
    attached = 0; #1;
    chk("R13 output holds before edge", status_word, 16'h0084);
    step();
    chk("R13 output follows after edge", status_word, 16'h0004);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule